// File: doc/BRIEF.md
# Manchester Code Violation Counter

This block watches a Manchester-coded line that has already been sampled twice per bit, once in each half of the symbol. In a correct Manchester stream the level changes in the middle of every bit, so the line never holds the same value for more than two half-bit samples in a row. A window of the three most recent samples that are all equal, either all low or all high, means a mid-bit transition is missing. The block reports that as a transmission error.

Each such window raises a single-cycle violation pulse. The pulse feeds a saturating error counter, so the count is a running measure of link quality. The block does not need to know the data, the bit phase or any framing. A synchronous clear restarts the measurement. Decoding, clock recovery and display scaling are left to other blocks.

Top module: `mcv_monitor`

## Requirements
- R1: When the three most recent samples are all 0, `viol_pulse` is 1 in the cycle after the edge that captured the third of them.
- R2: When the three most recent samples are all 1, `viol_pulse` is 1 in the cycle after the edge that captured the third of them.
- R3: After reset, `viol_pulse` stays 0 until three samples have been captured. This holds even when those samples match the cleared window contents, which are 0.
- R4: A valid Manchester stream produces no violation pulses and leaves `err_count` at 0. In such a stream each bit is sent as the sample pair (b, not b).
- R5: A run of N equal samples with N > 3 gives N-2 pulses on consecutive cycles.
- R6: Each violation pulse increments `err_count` by one on the next clock edge.
- R7: `err_count` (16 bits) saturates at 65535 and stays there while further violations arrive.
- R8: When `clear` is sampled high, `err_count` becomes 0 on that edge. `clear` takes priority over an increment due on the same edge.
- R9: While `rst` is sampled high, `viol_pulse` is 0 and `err_count` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit sampling clock, two edges per bit |
| rst | input | 1 | Synchronous reset, active high |
| line_bit | input | 1 | Sampled line value, captured on each rising edge |
| clear | input | 1 | Synchronous counter clear, active high |
| viol_pulse | output | 1 | One cycle per window of three equal samples |
| err_count | output | 16 | Saturating violation count |

## Verification
The violation pulse is due one cycle after the rising edge that captures the sample completing a three-equal window. The count changes one edge later than the pulse, or on the same edge as a clear or a reset. For every driven cycle, the driver predicts both outputs with these latencies and queues the prediction. The monitor compares each queued item 1 ns after the following rising edge. By then that edge's results have settled, and the next inputs have not yet been driven.

// File: rtl/mcv_pkg.sv
package mcv_pkg;

  localparam int unsigned MCV_WIN_MAX = 8;

  // True when the first n bits of w all share one value.
  function automatic logic win_uniform(input logic [MCV_WIN_MAX-1:0] w,
                                       input int unsigned n);
    logic same;
    same = 1'b1;
    for (int unsigned i = 1; i < MCV_WIN_MAX; i++) begin
      if (i < n && w[i] != w[0]) same = 1'b0;
    end
    return same;
  endfunction

endpackage

// File: rtl/mcv_window.sv
module mcv_window
  import mcv_pkg::*;
#(
  parameter int unsigned WIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_bit,
  output logic viol,
  output logic primed
);

  localparam int unsigned FW = $clog2(WIN + 1);
  localparam int unsigned PAD = MCV_WIN_MAX - WIN;

  logic [WIN-1:0] hist_q;
  logic [FW-1:0]  fill_q;
  logic           same_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= {hist_q[WIN-2:0], line_bit};
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  assign primed = (fill_q == FW'(WIN));
  assign same_w = win_uniform({{PAD{1'b0}}, hist_q}, WIN);
  assign viol   = primed && same_w;

  // R3: the first cycle after reset never shows a violation
  p_guard_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !viol);

  generate
    if (WIN == 3) begin : g_win3_chk
      // R1 R2: a pulse is backed by three equal captured line samples
      p_equal_run_r1: assert property (@(posedge clk) disable iff (rst)
        viol |-> ($past(line_bit, 1) == $past(line_bit, 2)) &&
                 ($past(line_bit, 2) == $past(line_bit, 3)));
      // R4: a transition among the last three samples forbids a pulse
      p_transition_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(line_bit, 1) != $past(line_bit, 2)) |-> !viol);
    end
  endgenerate

endmodule

// File: rtl/mcv_err_counter.sv
module mcv_err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear)  count <= '0;
    else if (bump)     count <= sat_step(count);
  end

  // R6: a pulse below the ceiling adds exactly one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (bump && !clear && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  // R7: the ceiling holds under further pulses
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clear) |=> count == CNT_MAX);
  // R8: clear wins over an increment
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == '0);
  // R6: without pulse or clear the count is held
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!bump && !clear) |=> $stable(count));

endmodule

// File: rtl/mcv_monitor.sv
module mcv_monitor #(
  parameter int unsigned WIN   = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_bit,
  input  logic             clear,
  output logic             viol_pulse,
  output logic [CNT_W-1:0] err_count
);

  logic win_viol;
  logic win_primed;

  mcv_window #(.WIN(WIN)) u_window (
    .clk      (clk),
    .rst      (rst),
    .line_bit (line_bit),
    .viol     (win_viol),
    .primed   (win_primed)
  );

  mcv_err_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .bump  (win_viol),
    .count (err_count)
  );

  assign viol_pulse = win_viol;

  // R9: reset leaves pulse and count at zero
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!viol_pulse && err_count == '0));
  // R3: no pulse before the window is full
  p_primed_r3: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> win_primed);

endmodule

// File: tb/mcv_monitor_tb_top.sv
module mcv_monitor_tb_top;

  typedef struct {
    logic        v;
    logic [15:0] c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_bit = 1'b0;
  logic        clear = 1'b0;
  logic        viol_pulse;
  logic [15:0] err_count;

  int checks = 0;
  int failures = 0;
  exp_t q[$];

  // bench model state
  logic [2:0]  m_hist = 3'b000;
  int          m_seen = 0;
  logic        m_viol = 1'b0;
  logic [15:0] m_cnt = 16'd0;

  always #2 clk = ~clk;

  mcv_monitor dut_i (
    .clk        (clk),
    .rst        (rst),
    .line_bit   (line_bit),
    .clear      (clear),
    .viol_pulse (viol_pulse),
    .err_count  (err_count)
  );

  task automatic step(input logic s, input logic c, input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    line_bit = s;
    clear    = c;
    rst      = r;
    if (r) begin
      m_hist = 3'b000; m_seen = 0; m_viol = 1'b0; m_cnt = 16'd0;
    end else begin
      if (c)                          m_cnt = 16'd0;
      else if (m_viol && m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
      m_hist = {m_hist[1:0], s};
      if (m_seen < 3) m_seen++;
      m_viol = (m_seen == 3) && (m_hist == 3'b000 || m_hist == 3'b111);
    end
    e.v = m_viol; e.c = m_cnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_bit(input logic b, input string tag);
    step(b, 1'b0, 1'b0, tag);
    step(~b, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (viol_pulse !== e.v) begin
        failures++;
        $display("FAIL %s viol_pulse actual=%0b expected=%0b t=%0t", e.tag, viol_pulse, e.v, $time);
      end
      checks++;
      if (err_count !== e.c) begin
        failures++;
        $display("FAIL %s err_count actual=%0d expected=%0d t=%0t", e.tag, err_count, e.c, $time);
      end
    end
  end

  initial begin : watchdog
    #(150000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    logic [7:0] lf;
    // R9 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R9");
    // R3 zeros right after reset: window matches cleared contents
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    // R4 clean stream, pseudo-random bits
    step(1'b0, 1'b1, 1'b0, "R8");
    lf = 8'hA5;
    for (int i = 0; i < 48; i++) begin
      send_bit(lf[0], "R4");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    // R1 flipped second half of a 0 bit after a 1 bit: 1,0,0,0
    send_bit(1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
    send_bit(1'b1, "R1");
    send_bit(1'b0, "R4");
    // R2 flipped second half of a 1 bit after a 0 bit: 0,1,1,1
    send_bit(1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, "R2");
    send_bit(1'b0, "R2");
    send_bit(1'b1, "R4");
    // R5 run of six ones gives four pulses
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R5");
    send_bit(1'b0, "R6");
    // R8 clear on the edge where an increment is due
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    send_bit(1'b0, "R8");
    // R3 reset in mid stream, then zeros
    step(1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R3");
    // R7 saturation with a long constant run
    for (int i = 0; i < 65545; i++) step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R8");
    send_bit(1'b1, "R4");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule